// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a small register bus. Once enabled and fed, it counts down by one on every slow tick, where a tick is a single-cycle enable supplied from outside. One tick before the count runs out, it latches a warning event that can drive an interrupt. When the count expires, it emits a one-cycle system reset pulse, records the timeout in a sticky status register and reloads itself from the programmed timeout. It then keeps running until it is fed again or shut off.

The operations that could disarm or misreport the watchdog are guarded by 16-bit keys. A feed needs its own key. Shutting the timer off takes two keys written in order to two separate registers. Bringing a stopped timer back needs a resume key, and clearing the timeout status needs a clear key. A debug input normally freezes the countdown, and a keep-alive bit overrides that freeze. Software can read the live count together with a flag that is set while the readable copy is still catching up with the counter.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is stopped: the shutdown register (0x0C) reads 0xDABE, status (0x10) reads 0x0000, the count (0x14) reads 0, irq and sys_rst are low, and the timeout register (0x04) reads the TMO_RST parameter (default 6000).
- R2: Writing 0xFEED to 0x00 while the timer is enabled loads the count from the timeout register. Any other value written there, and any write there while the timer is stopped, leaves the count unchanged.
- R3: While the timer is enabled and fed, each cycle with tick_en high lowers the count by one. Bits 14:0 of 0x14 show the count. Bit 15 reads 1 in the cycle right after the count changes and reads 0 once the readable copy matches the count.
- R4: A tick taken with a count of 1 or 0 drives sys_rst high for exactly the next cycle and reloads the count from the timeout register. The timer stays enabled and keeps counting on later ticks.
- R5: After an expiry, status (0x10) reads 0xCFE8. Writing 0xE8B4 there returns it to 0x0000, and any other value written there leaves it set.
- R6: Writing 0x2BAD to 0x08 and then 0xCAFE to 0x0C stops the timer. The register at 0x0C then reads 0xDABE, ticks leave the count unchanged, and feeds are ignored.
- R7: The timer stays enabled (0x0C reads 0x0000) if 0xCAFE is written without an immediately armed 0x2BAD. Writing a wrong value to 0x08 or to 0x0C cancels a half-completed shutdown sequence.
- R8: Writing 0xACED to 0x1C re-enables a stopped timer, so 0x0C reads 0x0000. The count holds until the next feed.
- R9: A tick that takes the count from 2 to 1 sets bit 0 of the event register (0x20). Writing 1 to bit 0 of 0x20 clears it.
- R10: irq is high exactly when event bit 0 and mask bit 0 (register 0x24) are both set.
- R11: While bit 0 of the force register (0x28) is set, event bit 0 becomes set.
- R12: Bit 1 of 0x18 reads the dbg_mode input. While dbg_mode is high and bit 0 of 0x18 is clear, ticks leave the count unchanged. With bit 0 set, counting continues.
- R13: The timeout register keeps only bits 14:0 of a write, so writing 0xFFFF reads back as 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle pulse per countdown step |
| dbg_mode | input | 1 | Debug mode in progress; freezes the countdown unless overridden |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Warning interrupt |
| sys_rst | output | 1 | One-cycle system reset pulse on expiry |

## Verification
The countdown is tried with randomly chosen timeouts and tick counts, which separates a correct reload and decrement from off-by-one counting. Random non-key values are written to the feed register and must not reload the count. Directed runs drive the count down through 2, 1 and expiry; these show whether the warning and the reset land on the right tick and whether the timer re-arms afterwards. The shutdown sequence is attempted correctly, out of order and with wrong keys in between, which tells a real two-step lock apart from one that accepts either key alone.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int AW = 6;
  localparam int DW = 16;

  // register byte offsets
  localparam logic [AW-1:0] A_FEED = 6'h00;
  localparam logic [AW-1:0] A_TMO  = 6'h04;
  localparam logic [AW-1:0] A_OFF1 = 6'h08;
  localparam logic [AW-1:0] A_OFF2 = 6'h0C;
  localparam logic [AW-1:0] A_STAT = 6'h10;
  localparam logic [AW-1:0] A_CNT  = 6'h14;
  localparam logic [AW-1:0] A_DBG  = 6'h18;
  localparam logic [AW-1:0] A_RES  = 6'h1C;
  localparam logic [AW-1:0] A_EVT  = 6'h20;
  localparam logic [AW-1:0] A_MSK  = 6'h24;
  localparam logic [AW-1:0] A_FRC  = 6'h28;

  // keys and status codes
  localparam logic [DW-1:0] K_FEED    = 16'hFEED;
  localparam logic [DW-1:0] K_OFF1    = 16'h2BAD;
  localparam logic [DW-1:0] K_OFF2    = 16'hCAFE;
  localparam logic [DW-1:0] K_RESUME  = 16'hACED;
  localparam logic [DW-1:0] K_CLRSTAT = 16'hE8B4;
  localparam logic [DW-1:0] V_STOPPED = 16'hDABE;
  localparam logic [DW-1:0] V_FIRED   = 16'hCFE8;

  // a tick at this count value ends the period
  function automatic logic ends_now(input int unsigned c);
    return c <= 1;
  endfunction

  // a tick at this count value is the last one before expiry
  function automatic logic warns_now(input int unsigned c);
    return c == 2;
  endfunction
endpackage

// File: rtl/kwd_keyguard.sv
module kwd_keyguard
  import kwd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_off1,
  input  logic          wr_off2,
  input  logic          wr_res,
  input  logic [DW-1:0] wdata,
  output logic          stopped,
  output logic          armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stopped <= 1'b1;
      armed   <= 1'b0;
    end else begin
      if (wr_off1) armed <= (wdata == K_OFF1);
      if (wr_off2) begin
        if (armed && wdata == K_OFF2) stopped <= 1'b1;
        armed <= 1'b0;
      end
      if (wr_res && wdata == K_RESUME) stopped <= 1'b0;
    end
  end

  // R7: shutdown only follows an armed first key
  p_stop_needs_arm_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(stopped) |-> $past(armed));
endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown
  import kwd_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_seen_o,
  output logic             warn_o,
  output logic             expire_o,
  output logic             sys_rst_o
);
  logic step;
  assign step     = tick_i && active_i;
  assign warn_o   = step && warns_now(32'(cnt_o));
  assign expire_o = step && ends_now(32'(cnt_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o      <= '0;
      cnt_seen_o <= '0;
      sys_rst_o  <= 1'b0;
    end else begin
      cnt_seen_o <= cnt_o;
      sys_rst_o  <= expire_o;
      if (load_i || expire_o) cnt_o <= tmo_i;
      else if (step)          cnt_o <= cnt_o - 1'b1;
    end
  end

  // R4: reset output is a single-cycle pulse
  p_rst_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |=> !sys_rst_o);
  // R4: expiry reloads from the timeout value
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> cnt_o == $past(tmo_i));
  // R3: count moves only on a load or a tick
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick_i) && !$past(load_i)) |-> $stable(cnt_o));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int               CNT_W   = 15,
  parameter logic [CNT_W-1:0] TMO_RST = 15'd6000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          dbg_mode,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          sys_rst
);
  localparam int PAD = DW - CNT_W;

  logic [CNT_W-1:0] tmo_q, cnt, cnt_seen;
  logic status_q, evt_q, msk_q, frc_q, keep_q, running_q;
  logic stopped, armed, warn, expire, feed_ok, active, clr_status;

  function automatic logic hit(input logic [AW-1:0] a);
    return bus_wr && bus_addr == a;
  endfunction

  assign feed_ok    = hit(A_FEED) && bus_wdata == K_FEED && !stopped;
  assign clr_status = hit(A_STAT) && bus_wdata == K_CLRSTAT;
  assign active     = running_q && !stopped && (!dbg_mode || keep_q);

  kwd_keyguard u_guard (
    .clk(clk), .rst(rst),
    .wr_off1(hit(A_OFF1)), .wr_off2(hit(A_OFF2)), .wr_res(hit(A_RES)),
    .wdata(bus_wdata), .stopped(stopped), .armed(armed)
  );

  kwd_countdown #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick_i(tick_en), .active_i(active),
    .load_i(feed_ok), .tmo_i(tmo_q), .cnt_o(cnt), .cnt_seen_o(cnt_seen),
    .warn_o(warn), .expire_o(expire), .sys_rst_o(sys_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q     <= TMO_RST;
      status_q  <= 1'b0;
      evt_q     <= 1'b0;
      msk_q     <= 1'b0;
      frc_q     <= 1'b0;
      keep_q    <= 1'b0;
      running_q <= 1'b0;
    end else begin
      if (hit(A_TMO)) tmo_q  <= bus_wdata[CNT_W-1:0];
      if (hit(A_MSK)) msk_q  <= bus_wdata[0];
      if (hit(A_FRC)) frc_q  <= bus_wdata[0];
      if (hit(A_DBG)) keep_q <= bus_wdata[0];
      if (expire)          status_q <= 1'b1;
      else if (clr_status) status_q <= 1'b0;
      if (warn || frc_q)                    evt_q <= 1'b1;
      else if (hit(A_EVT) && bus_wdata[0])  evt_q <= 1'b0;
      if (stopped)      running_q <= 1'b0;
      else if (feed_ok) running_q <= 1'b1;
    end
  end

  assign irq = evt_q && msk_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TMO:  bus_rdata = {{PAD{1'b0}}, tmo_q};
      A_OFF2: bus_rdata = stopped ? V_STOPPED : '0;
      A_STAT: bus_rdata = status_q ? V_FIRED : '0;
      A_CNT:  bus_rdata = {(cnt_seen != cnt), {(PAD-1){1'b0}}, cnt_seen};
      A_DBG:  bus_rdata = {{(DW-2){1'b0}}, dbg_mode, keep_q};
      A_EVT:  bus_rdata = {{(DW-1){1'b0}}, evt_q};
      A_MSK:  bus_rdata = {{(DW-1){1'b0}}, msk_q};
      A_FRC:  bus_rdata = {{(DW-1){1'b0}}, frc_q};
      default: bus_rdata = '0;
    endcase
  end

  // R5: timeout status stays set until the clear key
  p_status_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(status_q) && !$past(clr_status)) |-> status_q);
  // R9: the last tick before expiry latches the event
  p_warn_evt_r9: assert property (@(posedge clk) disable iff (rst)
    warn |=> evt_q);
  // R6: a stopped timer neither counts nor fires
  p_quiet_when_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !expire);
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, dbg_mode = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq, sys_rst;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst(rst), .tick_en(tick_en), .dbg_mode(dbg_mode),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .sys_rst(sys_rst)
  );

  function automatic int after_ticks(int t, int k);
    return t - k;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output int v);
    bus_addr = a; #0.5; v = int'(bus_rdata);
  endtask

  task automatic tick();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cnt_is(string req, int exp);
    int v;
    idle(1); rd(6'h14, v); check(req, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, t, k;
    void'($urandom(32'h5EED));
    idle(3); rst = 1'b0; idle(1);
    // R1 reset state
    rd(6'h0C, v); check("R1 stopped", v, 16'hDABE);
    rd(6'h10, v); check("R1 status", v, 0);
    rd(6'h14, v); check("R1 count", v, 0);
    rd(6'h04, v); check("R1 timeout", v, 6000);
    check("R1 irq", int'(irq), 0);
    check("R1 sys_rst", int'(sys_rst), 0);
    // R2 feed while stopped is ignored
    wr(6'h00, 16'hFEED); cnt_is("R2 feed stopped", 0);
    // R8 resume, count holds until feed
    wr(6'h1C, 16'hACED);
    rd(6'h0C, v); check("R8 enabled", v, 0);
    tick(); cnt_is("R8 hold", 0);
    // R13 width mask
    wr(6'h04, 16'hFFFF); rd(6'h04, v); check("R13 mask", v, 16'h7FFF);
    // random countdown R2 R3
    for (int i = 0; i < 12; i++) begin
      t = 3 + int'($urandom % 20);
      k = int'($urandom % (t - 1));
      wr(6'h04, 16'(t)); wr(6'h00, 16'hFEED);
      cnt_is("R2 load", t);
      wr(6'h00, 16'h1000 | 16'($urandom % 16'hE000));
      repeat (k) tick();
      cnt_is("R3 count", after_ticks(t, k));
      wr(6'h00, 16'hFEED); cnt_is("R2 refeed", t);
    end
    rd(6'h20, v); check("R9 no event early", v, 0);
    // R3 transition flag
    tick(); rd(6'h14, v); check("R3 unstable", v >> 15, 1);
    idle(1); rd(6'h14, v); check("R3 stable", v, after_ticks(t, 1));
    // R9 R10 R4 R5
    wr(6'h24, 16'h0001); wr(6'h04, 16'd4); wr(6'h00, 16'hFEED);
    tick(); tick(); rd(6'h20, v); check("R9 before", v, 0);
    tick(); rd(6'h20, v); check("R9 warn", v, 1);
    check("R10 irq", int'(irq), 1);
    tick(); check("R4 pulse", int'(sys_rst), 1);
    idle(1); check("R4 pulse end", int'(sys_rst), 0);
    rd(6'h14, v); check("R4 reload", v, 4);
    rd(6'h10, v); check("R5 fired", v, 16'hCFE8);
    tick(); cnt_is("R4 still running", 3);
    wr(6'h10, 16'h1234); rd(6'h10, v); check("R5 wrong key", v, 16'hCFE8);
    wr(6'h10, 16'hE8B4); rd(6'h10, v); check("R5 clear", v, 0);
    wr(6'h20, 16'h0001); rd(6'h20, v); check("R9 clear", v, 0);
    check("R10 irq low", int'(irq), 0);
    // R11 force, R10 mask
    wr(6'h24, 16'h0000); wr(6'h28, 16'h0001); idle(1);
    rd(6'h20, v); check("R11 force", v, 1);
    check("R10 masked", int'(irq), 0);
    wr(6'h28, 16'h0000); wr(6'h20, 16'h0001);
    rd(6'h20, v); check("R11 release", v, 0);
    // R7 bad shutdown attempts
    wr(6'h0C, 16'hCAFE); rd(6'h0C, v); check("R7 unarmed", v, 0);
    wr(6'h08, 16'h2BAD); wr(6'h08, 16'h1111); wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); check("R7 cancel1", v, 0);
    wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hBEEF); wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); check("R7 cancel2", v, 0);
    wr(6'h04, 16'd50); wr(6'h00, 16'hFEED); tick(); cnt_is("R7 counts", 49);
    // R6 shutdown
    wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); check("R6 stopped", v, 16'hDABE);
    tick(); cnt_is("R6 frozen", 49);
    wr(6'h04, 16'd7); wr(6'h00, 16'hFEED); cnt_is("R6 feed ignored", 49);
    // R12 debug freeze and keep-alive
    wr(6'h1C, 16'hACED); wr(6'h00, 16'hFEED);
    dbg_mode = 1'b1; rd(6'h18, v); check("R12 flag", v, 2);
    tick(); cnt_is("R12 frozen", 7);
    wr(6'h18, 16'h0001); tick(); cnt_is("R12 keep", 6);
    dbg_mode = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule